// File: doc/BRIEF.md
# Hashed Shared Page Table Walker

This block resolves a virtual page for a given process by searching a single page table that all processes share in memory. On a request it folds the process ID into the low bits of the virtual page number to choose a bucket. It adds the bucket offset to a table base to find the head entry, then follows the chain of linked entries with one memory read at a time until an entry carries both the requested page number and the requested process ID. The walk also stops when it reaches a null link or has visited a fixed number of entries.

Every entry takes four 32-bit words. Byte offset 0 holds the virtual page number, offset 4 the process ID, offset 8 the physical page number, and offset 12 the byte address of the next entry. All values are zero-extended into their words. The walker only reads the words it needs, so an entry whose page number differs costs two reads. The outcome is reported as a one-cycle completion pulse carrying a hit flag and the physical page number, after which the walker is idle again.

Top module: `hpt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `res_done` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk goes to `tbl_base + 16*b`, where the bucket b is `(vpn[IDX_W-1:0] XOR (pid << HSHIFT))` truncated to IDX_W bits.
- R3: Entry words are read at byte offsets 0 (page number), 4 (process ID), 8 (physical page) and 12 (next-entry byte address) from the entry start, and each word is compared or used zero-extended.
- R4: A hit is reported only for an entry whose page-number word and process-ID word both equal the request, with `res_hit` 1 and `res_ppn` taken from that entry's physical-page word.
- R5: When the page-number word differs, the next read is the link word of the same entry. When the page number matches but the process ID differs, the next read is also the link word. So a non-matching entry costs two or three reads and a hit entry costs three.
- R6: A link word of zero ends the walk as a miss, with `res_hit` 0 and `res_ppn` 0.
- R7: Once MAX_HOPS entries have been visited without a match, the walk ends as a miss without following the last link. A match in the MAX_HOPS-th entry is still a hit.
- R8: `res_done` is high for exactly one cycle and `req_ready` is high in the cycle after it. Requests presented while a walk is in progress are ignored and cause neither a read nor a result.
- R9: At most one read is outstanding: `mem_rd_en` lasts one cycle and is not raised again until `mem_rd_valid` has returned.
- R10: The walker waits any number of cycles for `mem_rd_valid`, and the result does not depend on read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | AW | Byte address of bucket 0 of the table |
| req_valid | input | 1 | Lookup request strobe |
| req_pid | input | PID_W | Process ID of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Read strobe to memory, one cycle per read |
| mem_addr | output | AW | Byte address of the word being read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DW | Read data word |
| res_done | output | 1 | One-cycle completion pulse |
| res_hit | output | 1 | Translation found, valid with `res_done` |
| res_ppn | output | PPN_W | Physical page number, zero on a miss |

## Verification
A bad word-select or field register shows up on the read bus at once: the read count of a walk moves away from two per skipped entry and three per hit entry, and the first address moves off the hashed bucket. A hop counter that is off by one shows only on chains that reach the limit, where a match in the last permitted entry turns into a miss or a looping chain costs two extra reads. A corrupted state register shows at the end of a walk, either as a missing or doubled completion pulse or as a read issued while the walker reports idle.

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int PID_W    = 8,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int IDX_W    = 10,
  parameter int HSHIFT   = 2,
  parameter int MAX_HOPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic             req_valid,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             req_ready,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             res_done,
  output logic             res_hit,
  output logic [PPN_W-1:0] res_ppn
);
  localparam int ENT_SH = 4;
  localparam int PS_W   = PID_W + HSHIFT;
  localparam int HOP_W  = $clog2(MAX_HOPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_DONE} st_t;
  localparam logic [1:0] W_VPN = 2'd0, W_PID = 2'd1, W_PPN = 2'd2, W_LNK = 2'd3;

  st_t              st;
  logic [1:0]       fld;
  logic [AW-1:0]    cur;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [HOP_W-1:0] hops;
  logic             hit_q;
  logic [PPN_W-1:0] ppn_q;

  wire [PS_W-1:0]  pid_sh   = PS_W'(req_pid) << HSHIFT;
  wire [IDX_W-1:0] bucket   = req_vpn[IDX_W-1:0] ^ IDX_W'(pid_sh);
  wire [AW-1:0]    head     = tbl_base + (AW'(bucket) << ENT_SH);
  wire             vpn_eq   = mem_rd_data == DW'(vpn_q);
  wire             pid_eq   = mem_rd_data == DW'(pid_q);
  wire             lnk_end  = mem_rd_data == '0;
  wire             last_hop = hops == HOP_W'(MAX_HOPS - 1);

  assign req_ready = st == S_IDLE;
  assign mem_rd_en = st == S_RD;
  assign mem_addr  = cur + (AW'(fld) << 2);
  assign res_done  = st == S_DONE;
  assign res_hit   = hit_q;
  assign res_ppn   = ppn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      fld   <= W_VPN;
      cur   <= '0;
      pid_q <= '0;
      vpn_q <= '0;
      hops  <= '0;
      hit_q <= 1'b0;
      ppn_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          pid_q <= req_pid;
          vpn_q <= req_vpn;
          cur   <= head;
          fld   <= W_VPN;
          hops  <= '0;
          hit_q <= 1'b0;
          ppn_q <= '0;
          st    <= S_RD;
        end
        S_RD: st <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          case (fld)
            W_VPN: begin
              fld <= vpn_eq ? W_PID : W_LNK;
              st  <= S_RD;
            end
            W_PID: begin
              fld <= pid_eq ? W_PPN : W_LNK;
              st  <= S_RD;
            end
            W_PPN: begin
              hit_q <= 1'b1;
              ppn_q <= mem_rd_data[PPN_W-1:0];
              st    <= S_DONE;
            end
            default: begin
              if (lnk_end || last_hop) begin
                st <= S_DONE;
              end else begin
                cur  <= mem_rd_data[AW-1:0];
                hops <= hops + 1'b1;
                fld  <= W_VPN;
                st   <= S_RD;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
`timescale 1ns/1ps
module hpt_walker_chk #(
  parameter int AW       = 32,
  parameter int PPN_W    = 20,
  parameter int MAX_HOPS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rd_valid,
  input logic             res_done,
  input logic             res_hit,
  input logic [PPN_W-1:0] res_ppn
);
  localparam int CW = $clog2(MAX_HOPS + 2) + 1;

  logic          outst;
  logic [CW-1:0] ent_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst   <= 1'b0;
      ent_cnt <= '0;
    end else begin
      if (mem_rd_en) outst <= 1'b1;
      else if (mem_rd_valid) outst <= 1'b0;
      if (req_ready) ent_cnt <= '0;
      else if (mem_rd_en && mem_addr[3:2] == 2'd0) ent_cnt <= ent_cnt + 1'b1;
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && !mem_rd_valid) |-> !mem_rd_en); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R8
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> req_ready); // R8
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en); // R8
  AST_MISS_ZERO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_hit) |-> res_ppn == '0); // R6
  AST_HOP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cnt <= CW'(MAX_HOPS)); // R7
endmodule

bind hpt_walker hpt_walker_chk #(.AW(AW), .PPN_W(PPN_W), .MAX_HOPS(MAX_HOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
  .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid), .res_done(res_done),
  .res_hit(res_hit), .res_ppn(res_ppn)
);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
  localparam int AW = 32, DW = 32, PID_W = 8, VPN_W = 20, PPN_W = 20;
  localparam int IDX_W = 8, HSHIFT = 2, MAX_HOPS = 4;
  localparam logic [31:0] BASE = 32'h200;
  localparam int NV = 9;
  // {pid, vpn, hit, ppn, reads}
  localparam logic [56:0] VEC [NV] = '{
    {8'h01, 20'h00010, 1'b1, 20'hAAAAA, 8'd3},
    {8'h02, 20'h0001C, 1'b1, 20'h0BBBB, 8'd5},
    {8'h01, 20'h00110, 1'b1, 20'h0CCCC, 8'd7},
    {8'h03, 20'h00018, 1'b0, 20'h00000, 8'd6},
    {8'h41, 20'h00010, 1'b0, 20'h00000, 8'd7},
    {8'h00, 20'h00033, 1'b0, 20'h00000, 8'd2},
    {8'h00, 20'h00050, 1'b0, 20'h00000, 8'd8},
    {8'h00, 20'h00060, 1'b1, 20'h0DDDD, 8'd9},
    {8'h00, 20'h00160, 1'b0, 20'h00000, 8'd8}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             req_ready, mem_rd_en, res_done, res_hit;
  logic [AW-1:0]    mem_addr;
  logic             mem_rd_valid = 1'b0;
  logic [DW-1:0]    mem_rd_data = '0;
  logic [PPN_W-1:0] res_ppn;

  logic [31:0] mem [2048];
  int lat = 0, cnt = 0, rd_total = 0, mark = 0;
  logic pend = 1'b0;
  logic [31:0] paddr = '0, first_addr = '0;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  hpt_walker #(.AW(AW), .DW(DW), .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .IDX_W(IDX_W), .HSHIFT(HSHIFT), .MAX_HOPS(MAX_HOPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_base(BASE), .req_valid(req_valid),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .res_done(res_done), .res_hit(res_hit),
    .res_ppn(res_ppn));

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[paddr[12:2]];
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_rd_en) begin
      if (lat == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[mem_addr[12:2]];
      end else begin
        pend  <= 1'b1;
        cnt   <= lat - 1;
        paddr <= mem_addr;
      end
    end
    if (mem_rd_en) begin
      if (rd_total == mark) first_addr <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v, input logic [31:0] p,
                     input logic [31:0] f, input logic [31:0] l);
    mem[a[12:2]]     = v;
    mem[a[12:2] + 1] = p;
    mem[a[12:2] + 2] = f;
    mem[a[12:2] + 3] = l;
  endtask

  function automatic logic [31:0] head_of(input logic [7:0] pid, input logic [19:0] vpn);
    logic [7:0] b;
    b = vpn[7:0] ^ (pid << 2);
    return BASE + {20'd0, b, 4'd0};
  endfunction

  task automatic lookup(input logic [7:0] pid, input logic [19:0] vpn,
                        output logic hit, output logic [19:0] ppn,
                        output int nrd, output logic [31:0] fa, output bit seen);
    int n;
    @(negedge clk);
    mark = rd_total;
    req_valid = 1'b1; req_pid = pid; req_vpn = vpn;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    seen = res_done;
    hit = res_hit; ppn = res_ppn;
    nrd = rd_total - mark; fa = first_addr;
  endtask

  initial begin
    logic hit; logic [19:0] ppn; int nrd; logic [31:0] fa; bit seen;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    put(32'h340,  32'h10,    32'd1, 32'hAAAAA, 32'h1400);
    put(32'h1400, 32'h1C,    32'd2, 32'h0BBBB, 32'h1410);
    put(32'h1410, 32'h110,   32'd1, 32'h0CCCC, 32'h0);
    put(32'h700,  32'h7FFFF, 32'd9, 32'h1,     32'h1420);
    put(32'h1420, 32'h7FFFE, 32'd9, 32'h2,     32'h700);
    put(32'h800,  32'h1,     32'd0, 32'h3,     32'h1430);
    put(32'h1430, 32'h2,     32'd0, 32'h4,     32'h1440);
    put(32'h1440, 32'h3,     32'd0, 32'h5,     32'h1450);
    put(32'h1450, 32'h60,    32'd0, 32'h0DDDD, 32'h1460);
    put(32'h1460, 32'h160,   32'd0, 32'h0EEEE, 32'h0);

    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    check(res_done === 1'b0, "R1 done after reset", 32'(res_done), 0);
    check(mem_rd_en === 1'b0, "R1 read after reset", 32'(mem_rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int pass = 0; pass < 2; pass++) begin
      lat = (pass == 0) ? 0 : 3; // R10: latency must not matter
      for (int v = 0; v < NV; v++) begin
        logic [7:0] p; logic [19:0] a; logic eh; logic [19:0] ep; logic [7:0] er;
        {p, a, eh, ep, er} = VEC[v];
        lookup(p, a, hit, ppn, nrd, fa, seen);
        check(seen, "R8/R10 completion seen", 32'(seen), 1);
        check(hit === eh, "R4/R6/R7 hit flag", 32'(hit), 32'(eh));
        check(ppn === ep, "R4/R6 ppn", 32'(ppn), 32'(ep));
        check(nrd == int'(er), "R3/R5/R7 read count", nrd, 32'(er));
        check(fa === head_of(p, a), "R2 first address", fa, head_of(p, a));
        @(negedge clk);
        check(res_done === 1'b0 && req_ready === 1'b1, "R8 pulse width",
              32'({res_done, req_ready}), 32'b01);
      end
    end

    // R8: request during a walk is ignored
    lat = 1;
    @(negedge clk);
    mark = rd_total;
    req_valid = 1'b1; req_pid = 8'h02; req_vpn = 20'h1C;
    @(negedge clk);
    req_pid = 8'h01; req_vpn = 20'h10;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 1000 && !res_done; n++) @(negedge clk);
    check(res_hit === 1'b1 && res_ppn === 20'h0BBBB, "R8 busy request ignored",
          32'(res_ppn), 32'h0BBBB);
    check(rd_total - mark == 5, "R8 busy request reads", rd_total - mark, 5);
    mark = rd_total;
    begin
      int dones = 0;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (res_done) dones++;
      end
      check(dones == 0, "R8 no second result", dones, 0);
    end
    check(rd_total == mark, "R8 no reads while idle", rd_total, mark);

    // R9 spot check: strobe stays low across a long read
    lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_pid = 8'h01; req_vpn = 20'h10;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int strobes = 0;
      for (int n = 0; n < 6; n++) begin
        if (mem_rd_en) strobes++;
        @(negedge clk);
      end
      check(strobes == 1, "R9 single strobe per read", strobes, 1);
    end
    for (int n = 0; n < 1000 && !res_done; n++) @(negedge clk);
    check(res_hit === 1'b1 && res_ppn === 20'hAAAAA, "R10 slow memory hit",
          32'(res_ppn), 32'hAAAAA);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule